// File: doc/BRIEF.md
# Supply-Dip Qualifier with Reset Drive

This block watches a single digital trip input. An analog comparator outside the block raises that input while the supply rail is at or below its threshold. The block only accepts a trip after it has been present for an unbroken run of clock cycles, which keeps short glitches from counting. The accepted condition then appears as a status flag that software can read over a simple read port. When the matching option is set, the accepted condition also becomes a system reset request and drives an active-low pin that other devices on the board can use.

Four latched option inputs set how the block behaves. The first powers the function as a whole. The second chooses between a polled-status mode and a forced-reset mode. The third keeps detection running while the device is in stop mode. The fourth bypasses the run-length filter. The persistence length, the address width, the data width, the status address and the flag bit position are all parameters.

Top module: `vdip_guard`

## Requirements
- R1: With bypass clear, `status` becomes 1 only after `trip_raw` has been sampled high on FILT_LEN (default 9) consecutive rising clock edges while the block is active. It becomes 1 right after the FILT_LEN-th such edge and not before.
- R2: When `opt_enable` is 0, `status` and `rst_req` are both 0 and `rst_pin_n` is 1, whatever `trip_raw` does.
- R3: When `opt_rst_en` is 0, `rst_req` stays 0 and `rst_pin_n` stays 1, even while `status` is 1.
- R4: When `opt_rst_en` is 1, `rst_req` equals `status`.
- R5: `rst_pin_n` is always the inverse of `rst_req`, so a supply reset pulls the pin low.
- R6: When `rd_en` is 1 and `rd_addr` equals 0xFE0F, `rd_data` carries `status` in bit 7 and 0 in bits 6..0. Every other address, and any cycle with `rd_en` at 0, reads as 0x00.
- R7: When `opt_bypass` is 1 and the block is active, `status` follows `trip_raw` combinationally, with no edge count.
- R8: When `stop_mode` is 1 and `opt_stop_en` is 0, the block is inactive: `status` is 0 and the run count is discarded. When `opt_stop_en` is 1, detection works in stop mode as it does outside it.
- R9: A single edge that samples `trip_raw` low clears the run count, so a run must start again from zero. The flag falls on the first edge at which `trip_raw` is sampled low.
- R10: `rst_req` stays high for as long as the accepted trip persists and releases on the same edge that clears the flag.
- R11: After power-on reset (`rst_n` low), the run count and the flag are 0, so `status`, `rst_req` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low power-on reset |
| trip_raw | input | 1 | Comparator output, high while the supply is at or below threshold |
| opt_enable | input | 1 | Option bit that powers the detector |
| opt_rst_en | input | 1 | Option bit that selects forced reset (1) or polled status (0) |
| opt_stop_en | input | 1 | Option bit that keeps detection active in stop mode |
| opt_bypass | input | 1 | Option bit that skips the persistence filter |
| stop_mode | input | 1 | High while the device is in stop mode |
| rd_en | input | 1 | Read strobe for the status register |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, the flag in bit STAT_BIT |
| status | output | 1 | Accepted supply-dip flag |
| rst_req | output | 1 | System reset request |
| rst_pin_n | output | 1 | Active-low external reset pin drive |

## Verification
The properties assume the option bits and `stop_mode` change only between clock edges, like any other synchronous control. They also assume `trip_raw` is already synchronous to `clk`, so the number of consecutive high samples is well defined. The stimulus changes every input on the falling edge and samples the outputs one nanosecond after the rising edge. It sweeps trip run lengths on both sides of the threshold, under every relevant option combination, with an interrupted run and with stop mode both gated and allowed.

// File: rtl/vdip_pkg.sv
package vdip_pkg;

   typedef struct packed {
      logic enable;
      logic rst_en;
      logic stop_en;
      logic bypass;
   } vdip_opts_t;

   function automatic int run_cnt_w(input int len);
      return (len < 2) ? 1 : $clog2(len + 1);
   endfunction

endpackage

// File: rtl/vdip_filter.sv
module vdip_filter #(
   parameter int FILT_LEN = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic trip,
   output logic flt_q
);
   localparam int CW = vdip_pkg::run_cnt_w(FILT_LEN);
   localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);
   localparam logic [CW-1:0] TOP  = CW'(FILT_LEN);

   generate
      if (FILT_LEN == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flt_q <= 1'b0;
            else        flt_q <= active & trip;
         end
      end else begin : g_count
         logic [CW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
               flt_q <= 1'b0;
            end else if (!active || !trip) begin
               run_q <= '0;
               flt_q <= 1'b0;
            end else begin
               if (run_q != TOP) run_q <= run_q + 1'b1;
               flt_q <= (run_q >= LAST);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/vdip_stat_reg.sv
module vdip_stat_reg #(
   parameter int              ADDR_W    = 16,
   parameter int              DATA_W    = 8,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE0F,
   parameter int              STAT_BIT  = 7
) (
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              flag,
   output logic [DATA_W-1:0] rd_data
);
   logic hit;
   assign hit = rd_en && (rd_addr == STAT_ADDR);

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         if (i == STAT_BIT) begin : g_flag
            assign rd_data[i] = hit & flag;
         end else begin : g_zero
            assign rd_data[i] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/vdip_rst_drv.sv
module vdip_rst_drv (
   input  logic rst_en,
   input  logic flag,
   output logic rst_req,
   output logic rst_pin_n
);
   always_comb begin
      rst_req   = rst_en & flag;
      rst_pin_n = ~rst_req;
   end
endmodule

// File: rtl/vdip_guard.sv
module vdip_guard #(
   parameter int                FILT_LEN  = 9,
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE0F,
   parameter int                STAT_BIT  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trip_raw,
   input  logic              opt_enable,
   input  logic              opt_rst_en,
   input  logic              opt_stop_en,
   input  logic              opt_bypass,
   input  logic              stop_mode,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              status,
   output logic              rst_req,
   output logic              rst_pin_n
);
   import vdip_pkg::*;

   generate
      if (FILT_LEN < 1) begin : g_bad_len
         $error("FILT_LEN must be at least 1");
      end
      if (STAT_BIT >= DATA_W || STAT_BIT < 0) begin : g_bad_bit
         $error("STAT_BIT must lie inside DATA_W");
      end
   endgenerate

   vdip_opts_t opts;
   logic       active;
   logic       flt_q;

   assign opts   = '{enable: opt_enable, rst_en: opt_rst_en,
                     stop_en: opt_stop_en, bypass: opt_bypass};
   assign active = opts.enable && (!stop_mode || opts.stop_en);
   assign status = active && (opts.bypass ? trip_raw : flt_q);

   vdip_filter #(.FILT_LEN(FILT_LEN)) u_filter (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .trip   (trip_raw),
      .flt_q  (flt_q)
   );

   vdip_stat_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .STAT_ADDR(STAT_ADDR), .STAT_BIT(STAT_BIT)
   ) u_stat (
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .flag    (status),
      .rd_data (rd_data)
   );

   vdip_rst_drv u_rst (
      .rst_en    (opts.rst_en),
      .flag      (status),
      .rst_req   (rst_req),
      .rst_pin_n (rst_pin_n)
   );
endmodule

// File: rtl/vdip_guard_chk.sv
module vdip_guard_chk #(
   parameter int                FILT_LEN  = 9,
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE0F,
   parameter int                STAT_BIT  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trip_raw,
   input logic              opt_enable,
   input logic              opt_rst_en,
   input logic              opt_stop_en,
   input logic              opt_bypass,
   input logic              stop_mode,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              status,
   input logic              rst_req,
   input logic              rst_pin_n
);
   localparam int RW = $clog2(FILT_LEN + 2);
   logic [RW-1:0] seen_q;
   logic          live;

   assign live = opt_enable && (!stop_mode || opt_stop_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                seen_q <= '0;
      else if (!(live && trip_raw)) seen_q <= '0;
      else if (seen_q < RW'(FILT_LEN)) seen_q <= seen_q + 1'b1;
   end

   // R1
   min_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status && !opt_bypass) |-> (seen_q >= RW'(FILT_LEN)));

   // R2
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !opt_enable |-> (!status && !rst_req));

   // R3
   polled_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !opt_rst_en |-> (!rst_req && rst_pin_n));

   // R4
   forced_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      opt_rst_en |-> (rst_req == status));

   // R5
   pin_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pin_n != rst_req);

   // R6
   read_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en || rd_addr != STAT_ADDR || !status) |-> (rd_data == '0));

   // R8
   stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_mode && !opt_stop_en) |-> !status);

   // R9
   drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!trip_raw && !opt_bypass) |=> (!status || opt_bypass));
endmodule

bind vdip_guard vdip_guard_chk #(
   .FILT_LEN(FILT_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .STAT_ADDR(STAT_ADDR), .STAT_BIT(STAT_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .trip_raw(trip_raw),
   .opt_enable(opt_enable), .opt_rst_en(opt_rst_en),
   .opt_stop_en(opt_stop_en), .opt_bypass(opt_bypass),
   .stop_mode(stop_mode), .rd_en(rd_en), .rd_addr(rd_addr),
   .rd_data(rd_data), .status(status), .rst_req(rst_req),
   .rst_pin_n(rst_pin_n)
);

// File: tb/tb_vdip_guard.sv
`timescale 1ns/1ps
module tb_vdip_guard;
   localparam int FL = 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trip_raw = 1'b0;
   logic        opt_enable = 1'b0, opt_rst_en = 1'b0, opt_stop_en = 1'b0, opt_bypass = 1'b0;
   logic        stop_mode = 1'b0;
   logic        rd_en = 1'b0;
   logic [15:0] rd_addr = 16'h0000;
   logic [7:0]  rd_data;
   logic        status, rst_req, rst_pin_n;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   vdip_guard dut (
      .clk(clk), .rst_n(rst_n), .trip_raw(trip_raw),
      .opt_enable(opt_enable), .opt_rst_en(opt_rst_en),
      .opt_stop_en(opt_stop_en), .opt_bypass(opt_bypass),
      .stop_mode(stop_mode), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .status(status), .rst_req(rst_req),
      .rst_pin_n(rst_pin_n)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic edge_wait();
      @(posedge clk);
      #1;
   endtask

   task automatic out_chk(input string tag, input logic st, input logic rq);
      chk({tag, " status"}, {7'b0, status}, {7'b0, st});
      chk({tag, " rst_req"}, {7'b0, rst_req}, {7'b0, rq});
      chk("R5 pin", {7'b0, rst_pin_n}, {7'b0, ~rq});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R11: state during and after power-on reset
      repeat (3) @(posedge clk);
      #1;
      rd_en = 1'b1; rd_addr = 16'hFE0F; opt_enable = 1'b1; trip_raw = 1'b1;
      #1;
      out_chk("R11", 1'b0, 1'b0);
      chk("R11 rd_data", rd_data, 8'h00);
      @(negedge clk);
      trip_raw = 1'b0;
      rst_n = 1'b1;
      edge_wait();
      out_chk("R11 post", 1'b0, 1'b0);

      // R1 R3 R4 R10: run-length sweep in both reset modes
      for (int re = 0; re < 2; re++) begin
         for (int len = 1; len <= 12; len++) begin
            @(negedge clk);
            opt_rst_en = re[0];
            trip_raw = 1'b1;
            for (int k = 1; k <= len; k++) begin
               edge_wait();
               out_chk(re ? "R1/R4" : "R1/R3", k >= FL, (k >= FL) && re[0]);
               chk("R6 rd_data", rd_data, (k >= FL) ? 8'h80 : 8'h00);
            end
            @(negedge clk);
            trip_raw = 1'b0;
            edge_wait();
            out_chk("R9/R10 release", 1'b0, 1'b0);
         end
      end

      // R9: a single low sample restarts the run
      @(negedge clk);
      opt_rst_en = 1'b1;
      trip_raw = 1'b1;
      repeat (FL - 1) edge_wait();
      @(negedge clk);
      trip_raw = 1'b0;
      edge_wait();
      @(negedge clk);
      trip_raw = 1'b1;
      for (int k = 1; k <= FL; k++) begin
         edge_wait();
         out_chk("R9 restart", k >= FL, k >= FL);
      end

      // R6: address sweep while flag is set
      for (int a = 0; a < 32; a++) begin
         logic [15:0] ad;
         @(negedge clk);
         ad = 16'hFE00 + 16'(a);
         rd_addr = ad;
         rd_en = a[0] | (ad == 16'hFE0F);
         #1;
         chk("R6 addr sweep", rd_data, (ad == 16'hFE0F) ? 8'h80 : 8'h00);
      end
      @(negedge clk);
      rd_en = 1'b0; rd_addr = 16'hFE0F;
      #1;
      chk("R6 rd_en low", rd_data, 8'h00);
      rd_en = 1'b1;

      // R2: disable drops outputs at once and blocks new runs
      @(negedge clk);
      opt_enable = 1'b0;
      #1;
      out_chk("R2 disable", 1'b0, 1'b0);
      for (int k = 1; k <= 12; k++) begin
         edge_wait();
         out_chk("R2 off", 1'b0, 1'b0);
      end
      @(negedge clk);
      opt_enable = 1'b1;
      trip_raw = 1'b0;
      edge_wait();

      // R8: stop mode gated off, then allowed
      @(negedge clk);
      stop_mode = 1'b1; opt_stop_en = 1'b0; trip_raw = 1'b1;
      for (int k = 1; k <= 12; k++) begin
         edge_wait();
         out_chk("R8 gated", 1'b0, 1'b0);
      end
      @(negedge clk);
      opt_stop_en = 1'b1;
      for (int k = 1; k <= 10; k++) begin
         edge_wait();
         out_chk("R8 allowed", k >= FL, k >= FL);
      end
      @(negedge clk);
      trip_raw = 1'b0; stop_mode = 1'b0; opt_stop_en = 1'b0;
      edge_wait();
      out_chk("R9 drop", 1'b0, 1'b0);

      // R7: bypass follows the trip without any edge
      @(negedge clk);
      opt_bypass = 1'b1;
      opt_rst_en = 1'b0;
      trip_raw = 1'b1;
      #1;
      out_chk("R7 bypass high/R3", 1'b1, 1'b0);
      chk("R7 rd_data", rd_data, 8'h80);
      trip_raw = 1'b0;
      #1;
      out_chk("R7 bypass low", 1'b0, 1'b0);
      opt_rst_en = 1'b1;
      trip_raw = 1'b1;
      #1;
      out_chk("R7 bypass/R4", 1'b1, 1'b1);
      opt_enable = 1'b0;
      #1;
      out_chk("R7 bypass/R2", 1'b0, 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule